// File: doc/BRIEF.md
# Renaming Completion Buffer Register File

This block is a physical register store that doubles as the architectural register file. Each of the 32 logical registers is renamed onto one of 64 physical entries when an instruction allocates a destination. Results go straight into the entry named by their physical index, in whatever order they arrive. No value is ever copied into a separate register file.

Every entry carries a logical tag, a most-recent flag, a privilege flag, a ready flag and a 32-bit value. Logical registers 0 to 14 are user-visible. Registers 15 to 31 exist only in privileged modes. A source lookup compares against most-recent entries only. In user mode it also skips privileged entries. The per-entry compare-enables are brought out, so the idle comparators can be observed. The value array is read only when the matched entry is ready. An unready hit leaves the data output holding its last value.

Two lookup ports, one allocate port, one writeback port and one release port all operate in the same cycle. Lookups see the state before that cycle's allocation. The one exception is a same-cycle writeback to the matched entry, which is forwarded.

Top module: `rename_cbuf`

## Requirements
- R1: After reset, logical register i (0..31) maps to physical entry i, which is most-recent, ready and holds 0. Privilege is set for i ≥ 15. Entries 32..63 are free, `full` is 0 and `alloc_preg` is 32.
- R2: `alloc_preg` always shows the lowest-numbered free entry. `full` is 1 exactly when no entry is free. An allocate request while `full` is 1 changes nothing.
- R3: A granted allocation marks the chosen entry in-use, most-recent and not ready, and tags it with `alloc_lreg`. It also clears the most-recent flag of the previous mapping of that logical register.
- R4: A writeback to an in-use entry stores `wb_data` and sets its ready flag, in any order across entries.
- R5: A lookup presented with `lk_en` returns `lk_hit` and `lk_preg` one clock later. `lk_preg` names the most-recent eligible entry tagged `lk_lreg`.
- R6: With `user_mode` at 1, entries whose privilege flag is set have their compare-enable at 0, so lookups of registers 15..31 miss.
- R7: A compare-enable bit is 1 only for an in-use, most-recent entry. At most 32 are set per port.
- R8: A hit on an unready entry, or a miss, gives `lk_rdy` = 0 and leaves `lk_data` at its previous value.
- R9: A lookup hit on an entry written back in the same cycle returns the new data with `lk_rdy` = 1.
- R10: A release frees the entry. It then becomes eligible for allocation in lowest-first order.
- R11: With `lk_en` at 0, that port's compare-enables are all 0 and its outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| user_mode | input | 1 | Lookups restricted to non-privileged entries |
| alloc_req | input | 1 | Allocate a destination |
| alloc_lreg | input | 5 | Logical register being renamed |
| alloc_gnt | output | 1 | Allocation accepted this cycle |
| alloc_preg | output | 6 | Lowest free physical entry |
| full | output | 1 | No free entry |
| wb_en | input | 1 | Writeback strobe |
| wb_preg | input | 6 | Writeback physical index |
| wb_data | input | 32 | Writeback value |
| rel_en | input | 1 | Release strobe |
| rel_preg | input | 6 | Entry to free |
| lk_en | input | 2 | Lookup enable per port |
| lk_lreg | input | 2x5 | Logical source per port |
| lk_hit | output | 2 | Lookup matched |
| lk_preg | output | 2x6 | Matched physical entry |
| lk_rdy | output | 2 | Matched entry ready (data valid) |
| lk_data | output | 2x32 | Source value |
| lk_cmp_en | output | 2x64 | Per-entry comparator enables |

## Verification
A writeback and a lookup can hit the same entry in one cycle. So can an allocation and a lookup of the same logical register. The bench allocates a register, looks it up while unready, and checks that the data output holds. It then issues the writeback and a lookup of that register in one cycle, and expects the new value with ready set. Lookups that coincide with an allocation are judged against the mapping that existed before that cycle.

// File: rtl/rename_cbuf.sv
module rename_cbuf #(
  parameter int NUM_PHYS = 64,
  parameter int NUM_LOG  = 32,
  parameter int NUM_USER = 15,
  parameter int DATA_W   = 32,
  parameter int NUM_LK   = 2,
  localparam int PW = $clog2(NUM_PHYS),
  localparam int LW = $clog2(NUM_LOG)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                user_mode,
  input  logic                                alloc_req,
  input  logic [LW-1:0]                       alloc_lreg,
  output logic                                alloc_gnt,
  output logic [PW-1:0]                       alloc_preg,
  output logic                                full,
  input  logic                                wb_en,
  input  logic [PW-1:0]                       wb_preg,
  input  logic [DATA_W-1:0]                   wb_data,
  input  logic                                rel_en,
  input  logic [PW-1:0]                       rel_preg,
  input  logic [NUM_LK-1:0]                   lk_en,
  input  logic [NUM_LK-1:0][LW-1:0]           lk_lreg,
  output logic [NUM_LK-1:0]                   lk_hit,
  output logic [NUM_LK-1:0][PW-1:0]           lk_preg,
  output logic [NUM_LK-1:0]                   lk_rdy,
  output logic [NUM_LK-1:0][DATA_W-1:0]       lk_data,
  output logic [NUM_LK-1:0][NUM_PHYS-1:0]     lk_cmp_en
);

  logic [NUM_PHYS-1:0] used, mr, priv, rdy;
  logic [LW-1:0]       tag [NUM_PHYS];
  logic [DATA_W-1:0]   val [NUM_PHYS];

  assign full      = &used;
  assign alloc_gnt = alloc_req & ~full;

  always_comb begin
    alloc_preg = '0;
    for (int j = NUM_PHYS-1; j >= 0; j--)
      if (!used[j]) alloc_preg = PW'(j);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < NUM_PHYS; j++) begin
        used[j] <= (j < NUM_LOG);
        mr[j]   <= (j < NUM_LOG);
        rdy[j]  <= (j < NUM_LOG);
        priv[j] <= (j >= NUM_USER) && (j < NUM_LOG);
        tag[j]  <= LW'(j);
        val[j]  <= '0;
      end
    end else begin
      if (wb_en && used[wb_preg]) begin
        val[wb_preg] <= wb_data;
        rdy[wb_preg] <= 1'b1;
      end
      if (rel_en) begin
        used[rel_preg] <= 1'b0;
        mr[rel_preg]   <= 1'b0;
      end
      if (alloc_gnt) begin
        for (int j = 0; j < NUM_PHYS; j++)
          if (used[j] && mr[j] && tag[j] == alloc_lreg) mr[j] <= 1'b0;
        used[alloc_preg] <= 1'b1;
        mr[alloc_preg]   <= 1'b1;
        rdy[alloc_preg]  <= 1'b0;
        priv[alloc_preg] <= (alloc_lreg >= LW'(NUM_USER));
        tag[alloc_preg]  <= alloc_lreg;
      end
    end
  end

  for (genvar p = 0; p < NUM_LK; p++) begin : g_lk
    logic [NUM_PHYS-1:0] ce, match;
    logic [PW-1:0]       idx;
    logic                fwd, ready_now;
    logic                h_q, r_q;
    logic [PW-1:0]       i_q;
    logic [DATA_W-1:0]   d_q;

    assign ce = {NUM_PHYS{lk_en[p]}} & used & mr & ~({NUM_PHYS{user_mode}} & priv);

    always_comb begin
      idx = '0;
      for (int j = 0; j < NUM_PHYS; j++) begin
        match[j] = ce[j] && (tag[j] == lk_lreg[p]);
        if (match[j]) idx = PW'(j);
      end
    end

    assign fwd       = wb_en && (wb_preg == idx);
    assign ready_now = (|match) && (rdy[idx] || fwd);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        h_q <= 1'b0;
        r_q <= 1'b0;
        i_q <= '0;
        d_q <= '0;
      end else if (lk_en[p]) begin
        h_q <= |match;
        i_q <= idx;
        r_q <= ready_now;
        if (ready_now) d_q <= fwd ? wb_data : val[idx];
      end
    end

    assign lk_cmp_en[p] = ce;
    assign lk_hit[p]    = h_q;
    assign lk_preg[p]   = i_q;
    assign lk_rdy[p]    = r_q;
    assign lk_data[p]   = d_q;

    // R7
    cmp_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lk_cmp_en[p]) <= NUM_LOG);
    // R6
    cmp_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
      user_mode |-> $countones(lk_cmp_en[p]) <= NUM_USER);
    // R8
    unready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_rdy[p] |-> $stable(lk_data[p]));
  end

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && !rel_en |=> full);
  // R3
  alloc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt |=> mr[$past(alloc_preg)] && !rdy[$past(alloc_preg)]);
  // R10
  rel_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en && !alloc_gnt |=> !used[$past(rel_preg)]);

endmodule

// File: tb/sim_rename_cbuf.sv
module sim_rename_cbuf;
  localparam int CLK_P = 10;
  localparam int NP = 64, NL = 32, NU = 15, DW = 32;

  logic clk = 0, rst_n = 0, user_mode = 0;
  logic alloc_req = 0, wb_en = 0, rel_en = 0;
  logic [4:0] alloc_lreg = 0;
  logic [5:0] wb_preg = 0, rel_preg = 0, alloc_preg;
  logic [DW-1:0] wb_data = 0;
  logic alloc_gnt, full;
  logic [1:0] lk_en = 0, lk_hit, lk_rdy;
  logic [1:0][4:0] lk_lreg = 0;
  logic [1:0][5:0] lk_preg;
  logic [1:0][DW-1:0] lk_data;
  logic [1:0][NP-1:0] lk_cmp_en;

  rename_cbuf u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  int errs = 0, chks = 0;
  logic          m_used [NP], m_mr [NP], m_priv [NP], m_rdy [NP];
  logic [4:0]    m_tag [NP];
  logic [DW-1:0] m_val [NP];
  logic          e_hit [2], e_rdy [2];
  logic [5:0]    e_preg [2];
  logic [DW-1:0] e_data [2];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit al, input int al_l, input bit wb, input int wb_p, input logic [DW-1:0] wb_d,
                      input bit rl, input int rl_p, input bit l0, input int l0_l, input bit l1, input int l1_l,
                      input bit um);
    int lowf;
    bit anyf;
    logic [NP-1:0] ece;
    @(negedge clk);
    alloc_req = al; alloc_lreg = 5'(al_l);
    wb_en = wb; wb_preg = 6'(wb_p); wb_data = wb_d;
    rel_en = rl; rel_preg = 6'(rl_p);
    lk_en = {l1, l0}; lk_lreg[0] = 5'(l0_l); lk_lreg[1] = 5'(l1_l);
    user_mode = um;
    #1;
    anyf = 0; lowf = 0;
    for (int j = NP-1; j >= 0; j--) if (!m_used[j]) begin anyf = 1; lowf = j; end
    chk(full == !anyf, "R2 full", 64'(full), 64'(!anyf));
    if (anyf) chk(alloc_preg == 6'(lowf), "R2 lowest free", 64'(alloc_preg), 64'(lowf));
    for (int p = 0; p < 2; p++) begin
      bit en = (p == 0) ? l0 : l1;
      int ll = (p == 0) ? l0_l : l1_l;
      for (int j = 0; j < NP; j++) ece[j] = en && m_used[j] && m_mr[j] && !(um && m_priv[j]);
      chk(lk_cmp_en[p] == ece, um ? "R6 cmp_en" : (en ? "R7 cmp_en" : "R11 cmp_en"), lk_cmp_en[p], ece);
      if (en) begin
        e_hit[p] = 0; e_rdy[p] = 0;
        for (int j = 0; j < NP; j++)
          if (ece[j] && m_tag[j] == 5'(ll)) begin
            bit f = wb && wb_p == j;
            e_hit[p] = 1; e_preg[p] = 6'(j);
            e_rdy[p] = m_rdy[j] || f;
            if (e_rdy[p]) e_data[p] = f ? wb_d : m_val[j];
          end
      end
    end
    @(posedge clk); #1;
    for (int p = 0; p < 2; p++) begin
      chk(lk_hit[p] == e_hit[p], "R5 hit", 64'(lk_hit[p]), 64'(e_hit[p]));
      if (e_hit[p]) chk(lk_preg[p] == e_preg[p], "R5 preg", 64'(lk_preg[p]), 64'(e_preg[p]));
      chk(lk_rdy[p] == e_rdy[p], "R8 rdy", 64'(lk_rdy[p]), 64'(e_rdy[p]));
      chk(lk_data[p] == e_data[p], wb ? "R9 data" : "R4 data", 64'(lk_data[p]), 64'(e_data[p]));
    end
    if (wb && m_used[wb_p]) begin m_val[wb_p] = wb_d; m_rdy[wb_p] = 1; end
    if (rl) begin m_used[rl_p] = 0; m_mr[rl_p] = 0; end
    if (al && anyf) begin
      for (int j = 0; j < NP; j++) if (m_used[j] && m_mr[j] && m_tag[j] == 5'(al_l)) m_mr[j] = 0;
      m_used[lowf] = 1; m_mr[lowf] = 1; m_rdy[lowf] = 0; m_tag[lowf] = 5'(al_l); m_priv[lowf] = (al_l >= NU);
    end
    alloc_req = 0; wb_en = 0; rel_en = 0; lk_en = 0;
  endtask

  task automatic sweep(input bit um);
    for (int l = 0; l < NL; l++) step(0, 0, 0, 0, 0, 0, 0, 1, l, 1, NL-1-l, um);
  endtask

  initial begin
    #(CLK_P*100000);
    errs++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    for (int j = 0; j < NP; j++) begin
      m_used[j] = j < NL; m_mr[j] = j < NL; m_rdy[j] = j < NL;
      m_priv[j] = j >= NU && j < NL; m_tag[j] = 5'(j); m_val[j] = 0;
    end
    for (int p = 0; p < 2; p++) begin e_hit[p] = 0; e_rdy[p] = 0; e_preg[p] = 0; e_data[p] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk(full == 0 && alloc_preg == 6'd32, "R1 reset alloc", {full, alloc_preg}, 64'd32);
    sweep(0);                                   // R1 reset mappings
    sweep(1);                                   // R6 user mode
    for (int i = NL-1; i >= 0; i--) step(0, 0, 1, i, 32'hC0DE0000 + 32'(i*7), 0, 0, 0, 0, 0, 0, 0); // R4
    sweep(0);
    step(1, 3, 0, 0, 0, 0, 0, 1, 3, 0, 0, 0);   // R3 alloc, lookup sees old
    step(0, 0, 0, 0, 0, 0, 0, 1, 3, 1, 3, 0);   // R8 unready hit holds
    step(0, 0, 1, 32, 32'hFEED0003, 0, 0, 1, 3, 1, 3, 0); // R9 forward
    for (int k = 0; k < 31; k++) step(1, (k*5+1) % NL, 0, 0, 0, 0, 0, 1, k, 0, 0, 0); // R2 fill
    step(1, 7, 0, 0, 0, 0, 0, 1, 7, 1, 3, 0);   // R2 request while full
    sweep(0);
    step(0, 0, 0, 0, 0, 1, 3, 0, 0, 0, 0, 0);   // R10 release old mapping
    step(0, 0, 0, 0, 0, 1, 40, 0, 0, 0, 0, 0);
    step(1, 9, 0, 0, 0, 0, 0, 1, 9, 0, 0, 1);
    step(1, 20, 1, 3, 32'h12345678, 0, 0, 1, 9, 1, 20, 0);
    sweep(1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);   // R11 idle ports hold
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule